// File: doc/BRIEF.md
# Configurable Multi-Line Video Delay

This block supplies the vertical taps of a two-dimensional image window. It keeps the previous raster lines of a pixel stream in one shared store of 32768 bits, built as eight byte-wide banks of 512 words. The store is partitioned in one of three layouts. Four delays of up to 1024 eight-bit pixels use two banks each, one bank per half line. Eight delays of up to 512 eight-bit pixels use one bank each. Four delays of up to 512 sixteen-bit pixels use one bank for the low byte and one for the high byte. Every delay in a layout has the same programmed length.

The delays form two equal groups. In series operation the second group continues the chain from the last delay of the first group, so every tap is one more line older than the one before it. In split operation the second group takes its own pixel stream from a second input. This lets a window combine two interlaced fields, or the same line from consecutive frames held in an external store. A shared column counter advances once per valid pixel. Each delay reads the old word at that column and then writes its new input there. All taps and the live pixels come out of one output register and are therefore aligned with one another.

Layout, group mode and length are sampled only on a pixel that carries the line-sync strobe. For one line after a change, the tap contents are stale.

Top module: `multiLineDelay`

## Requirements
- R1: While `rstN` is low and after reset, `outValid`, `outPixA`, `outPixB` and `outTaps` are all zero.
- R2: A pixel accepted with `pixValid` high appears on `outPixA` and `outPixB` unchanged one clock later, with `outValid` high in that same cycle.
- R3: The column counter runs from 0 to the active length minus one and then wraps to 0. In series operation, tap k (counting from 0) therefore presents the input accepted (k+1)·P valid pixels earlier, where P is the active length.
- R4: A pixel with both `pixValid` and `lineSync` high is stored at column 0 and is the first pixel to use the current `cfgLayout`, `cfgSplit` and `cfgLenM1`. These inputs have no effect on any other pixel. A tap that would need data from before the most recent configuration change is undefined.
- R5: A cycle with `pixValid` low stores nothing and leaves the column counter unchanged. In the next cycle `outValid` is low and `outTaps` holds its previous value.
- R6: `cfgLayout` = 0 selects four 8-bit delays with a length of up to 1024. Taps 0 to 3 are live.
- R7: `cfgLayout` = 1 selects eight 8-bit delays with a length of up to 512. Taps 0 to 7 are live.
- R8: `cfgLayout` = 2 or 3 selects four 16-bit delays with a length of up to 512. Taps 0 to 3 are live and carry full 16-bit pixels.
- R9: With `cfgSplit` = 0, the first delay of the second group (tap 2 in 4-delay layouts, tap 4 in the 8-delay layout) is fed from the output of the last delay of the first group.
- R10: With `cfgSplit` = 1, the second group is fed from `pixB`. Its first tap presents `pixB` from P valid pixels earlier, and each later tap in that group adds a further P.
- R11: A `cfgLenM1` above the limit of the selected layout (1023 or 511) is clamped to that limit.
- R12: Taps that are not live in the selected layout read zero. In 8-bit layouts bits 15:8 of every tap read zero, and bits 15:8 of `pixA` and `pixB` are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel strobe, one stored pixel per high cycle |
| lineSync | input | 1 | Marks the first pixel of a line (qualified by pixValid) |
| pixA | input | 16 | Primary pixel stream |
| pixB | input | 16 | Second stream, feeds group 2 in split operation |
| cfgLayout | input | 2 | 0: 4x1024 8-bit, 1: 8x512 8-bit, 2/3: 4x512 16-bit |
| cfgSplit | input | 1 | 0: groups in series, 1: group 2 fed from pixB |
| cfgLenM1 | input | 10 | Line length minus one |
| outValid | output | 1 | Outputs below hold a new aligned set |
| outPixA | output | 16 | Registered copy of pixA |
| outPixB | output | 16 | Registered copy of pixB |
| outTaps | output | 128 | Eight 16-bit taps, tap k in bits 16k+15:16k |

## Verification
A column counter that wraps one step early or late shifts every tap by a fixed offset. It miscompares on the first pixel of the first line whose data come from an earlier line, which is at most one line after the fill. A wrong bank choice, such as the half-line select of the long layout or the byte lanes of the wide layout, shows up only on columns of the upper half or on the high byte. For that reason the bench runs full-length lines in every layout. A broken group feed or a stale configuration register shows up from the second group's first live line, and idle-cycle faults show up in the cycle right after the gap.

// File: rtl/lineDelayPkg.sv
package lineDelayPkg;

  // How the shared banks are carved into line delays
  typedef enum logic [1:0] {
    LAY_LONG  = 2'd0,   // four 8-bit delays, two banks each (half line per bank)
    LAY_SHORT = 2'd1,   // eight 8-bit delays, one bank each
    LAY_WIDE  = 2'd2    // four 16-bit delays, low/high byte banks
  } layout_e;

  // Strobes and active configuration handed from control to datapath
  typedef struct packed {
    logic    shift;     // store one pixel this cycle
    logic    restart;   // line start, new configuration in force
    layout_e layout;
    logic    split;
  } ctrlStrobe_t;

endpackage

// File: rtl/lineDelayCtrl.sv
module lineDelayCtrl
  import lineDelayPkg::*;
#(
  parameter int BANK_DEPTH = 512,
  parameter int ADDR_W     = $clog2(BANK_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              lineSync,
  input  logic [1:0]        cfgLayout,
  input  logic              cfgSplit,
  input  logic [ADDR_W-1:0] cfgLenM1,
  output ctrlStrobe_t       strb,
  output logic [ADDR_W-1:0] colAddr
);

  localparam logic [ADDR_W-1:0] LONG_MAX  = ADDR_W'(2 * BANK_DEPTH - 1);
  localparam logic [ADDR_W-1:0] SHORT_MAX = ADDR_W'(BANK_DEPTH - 1);

  layout_e           actLayout, reqLayout, effLayout;
  logic              actSplit, effSplit;
  logic [ADDR_W-1:0] actLenM1, reqLenM1, effLenM1, lenCap;
  logic [ADDR_W-1:0] addrCnt, effAddr;
  logic              restart;

  assign restart = pixValid & lineSync;

  always_comb begin
    unique case (cfgLayout)
      2'd0:    reqLayout = LAY_LONG;
      2'd1:    reqLayout = LAY_SHORT;
      default: reqLayout = LAY_WIDE;
    endcase
    lenCap   = (reqLayout == LAY_LONG) ? LONG_MAX : SHORT_MAX;
    reqLenM1 = (cfgLenM1 > lenCap) ? lenCap : cfgLenM1;
  end

  // A line-start pixel already runs under the newly requested settings
  assign effLayout = restart ? reqLayout : actLayout;
  assign effSplit  = restart ? cfgSplit  : actSplit;
  assign effLenM1  = restart ? reqLenM1  : actLenM1;
  assign effAddr   = restart ? '0        : addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actLayout <= LAY_LONG;
      actSplit  <= 1'b0;
      actLenM1  <= LONG_MAX;
      addrCnt   <= '0;
    end else begin
      if (restart) begin
        actLayout <= reqLayout;
        actSplit  <= cfgSplit;
        actLenM1  <= reqLenM1;
      end
      if (pixValid)
        addrCnt <= (effAddr == effLenM1) ? '0 : effAddr + 1'b1;
    end
  end

  assign strb    = '{shift: pixValid, restart: restart, layout: effLayout, split: effSplit};
  assign colAddr = effAddr;

  // R3: counter never passes the active length
  p_addr_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt <= actLenM1);

  // R4: a line start puts the following pixel at column 1 (or 0 for length 1)
  p_restart_col_r4: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (addrCnt == ((actLenM1 == '0) ? '0 : ADDR_W'(1))));

  // R5: idle cycles change neither column nor configuration
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ($stable(addrCnt) && $stable(actLenM1) && $stable(actLayout)));

  // R11: short layouts never run with a length above one bank
  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (actLayout != LAY_LONG) |-> (actLenM1 <= SHORT_MAX));

endmodule

// File: rtl/lineDelayBank.sv
module lineDelayBank #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  parameter int A_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [A_W-1:0]    addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // old word is read in the same cycle the new one is written
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

endmodule

// File: rtl/lineDelayPath.sv
module lineDelayPath
  import lineDelayPkg::*;
#(
  parameter int PIX_W      = 16,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 512,
  parameter int ADDR_W     = $clog2(BANK_DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strb,
  input  logic [ADDR_W-1:0]          colAddr,
  input  logic [PIX_W-1:0]           pixA,
  input  logic [PIX_W-1:0]           pixB,
  output logic                       outValid,
  output logic [PIX_W-1:0]           outPixA,
  output logic [PIX_W-1:0]           outPixB,
  output logic [NUM_BANKS*PIX_W-1:0] outTaps
);

  localparam int BYTE_W = PIX_W / 2;
  localparam int BA_W   = $clog2(BANK_DEPTH);
  localparam int HALF   = NUM_BANKS / 2;

  logic             hiHalf;
  logic [BA_W-1:0]  bankAddr;
  logic [BYTE_W-1:0] bankRd [NUM_BANKS];
  logic [BYTE_W-1:0] bankWd [NUM_BANKS];
  logic              bankWe [NUM_BANKS];
  logic [PIX_W-1:0]  lineRd [NUM_BANKS];
  logic [PIX_W-1:0]  lineIn [NUM_BANKS];
  int                grpStart;

  assign hiHalf   = colAddr[ADDR_W-1];
  assign bankAddr = colAddr[BA_W-1:0];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      lineDelayBank #(.DEPTH(BANK_DEPTH), .DATA_W(BYTE_W)) u_bank (
        .clk  (clk),
        .we   (bankWe[b]),
        .addr (bankAddr),
        .wdata(bankWd[b]),
        .rdata(bankRd[b])
      );
    end
  endgenerate

  // Assemble logical line outputs from the banks
  always_comb begin
    for (int k = 0; k < NUM_BANKS; k++) lineRd[k] = '0;
    if (strb.layout == LAY_SHORT) begin
      for (int k = 0; k < NUM_BANKS; k++) lineRd[k] = {{BYTE_W{1'b0}}, bankRd[k]};
    end else begin
      for (int k = 0; k < HALF; k++) begin
        if (strb.layout == LAY_WIDE)
          lineRd[k] = {bankRd[2*k+1], bankRd[2*k]};
        else
          lineRd[k] = {{BYTE_W{1'b0}}, (hiHalf ? bankRd[2*k+1] : bankRd[2*k])};
      end
    end
  end

  // Feed of each line: live pixel, previous line, or second stream
  always_comb begin
    grpStart = (strb.layout == LAY_SHORT) ? HALF : HALF / 2;
    lineIn[0] = pixA;
    for (int k = 1; k < NUM_BANKS; k++) begin
      if (k == grpStart && strb.split) lineIn[k] = pixB;
      else                             lineIn[k] = lineRd[k-1];
    end
  end

  // Bank write steering
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankWe[b] = 1'b0;
      bankWd[b] = '0;
    end
    if (strb.layout == LAY_SHORT) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        bankWe[b] = strb.shift;
        bankWd[b] = lineIn[b][BYTE_W-1:0];
      end
    end else if (strb.layout == LAY_WIDE) begin
      for (int k = 0; k < HALF; k++) begin
        bankWe[2*k]   = strb.shift;
        bankWe[2*k+1] = strb.shift;
        bankWd[2*k]   = lineIn[k][BYTE_W-1:0];
        bankWd[2*k+1] = lineIn[k][PIX_W-1:BYTE_W];
      end
    end else begin
      for (int k = 0; k < HALF; k++) begin
        bankWe[2*k]   = strb.shift & ~hiHalf;
        bankWe[2*k+1] = strb.shift &  hiHalf;
        bankWd[2*k]   = lineIn[k][BYTE_W-1:0];
        bankWd[2*k+1] = lineIn[k][BYTE_W-1:0];
      end
    end
  end

  // One output register for live pixels and taps keeps them aligned
  layout_e layoutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixA  <= '0;
      outPixB  <= '0;
      outTaps  <= '0;
      layoutQ  <= LAY_LONG;
    end else begin
      outValid <= strb.shift;
      if (strb.shift) begin
        outPixA <= pixA;
        outPixB <= pixB;
        layoutQ <= strb.layout;
        for (int k = 0; k < NUM_BANKS; k++)
          outTaps[k*PIX_W +: PIX_W] <= lineRd[k];
      end
    end
  end

  logic upperAny;
  always_comb begin
    upperAny = 1'b0;
    for (int k = 0; k < NUM_BANKS; k++)
      upperAny = upperAny | (|outTaps[k*PIX_W+BYTE_W +: BYTE_W]);
  end

  // R2: output strobe follows the input strobe by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> outValid);
  p_idle_novalid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> !outValid);

  // R5: taps hold across idle cycles
  p_idle_taps_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(outTaps));

  // R12: narrow layouts never present a high byte
  p_narrow_upper_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && layoutQ != LAY_WIDE) |-> !upperAny);

  // R12: four-delay layouts leave the upper taps at zero
  p_unused_taps_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && layoutQ != LAY_SHORT) |-> (outTaps[NUM_BANKS*PIX_W-1:HALF*PIX_W] == '0));

endmodule

// File: rtl/multiLineDelay.sv
module multiLineDelay
  import lineDelayPkg::*;
#(
  parameter int PIX_W      = 16,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 512,
  localparam int ADDR_W    = $clog2(BANK_DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pixValid,
  input  logic                       lineSync,
  input  logic [PIX_W-1:0]           pixA,
  input  logic [PIX_W-1:0]           pixB,
  input  logic [1:0]                 cfgLayout,
  input  logic                       cfgSplit,
  input  logic [ADDR_W-1:0]          cfgLenM1,
  output logic                       outValid,
  output logic [PIX_W-1:0]           outPixA,
  output logic [PIX_W-1:0]           outPixB,
  output logic [NUM_BANKS*PIX_W-1:0] outTaps
);

  ctrlStrobe_t       strb;
  logic [ADDR_W-1:0] colAddr;

  lineDelayCtrl #(.BANK_DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pixValid (pixValid),
    .lineSync (lineSync),
    .cfgLayout(cfgLayout),
    .cfgSplit (cfgSplit),
    .cfgLenM1 (cfgLenM1),
    .strb     (strb),
    .colAddr  (colAddr)
  );

  lineDelayPath #(
    .PIX_W(PIX_W), .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .colAddr (colAddr),
    .pixA    (pixA),
    .pixB    (pixB),
    .outValid(outValid),
    .outPixA (outPixA),
    .outPixB (outPixB),
    .outTaps (outTaps)
  );

endmodule

// File: tb/multiLineDelay_test.sv
`timescale 1ns/1ps
module multiLineDelay_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pixValid = 1'b0;
  logic         lineSync = 1'b0;
  logic [15:0]  pixA = '0;
  logic [15:0]  pixB = '0;
  logic [1:0]   cfgLayout = '0;
  logic         cfgSplit = 1'b0;
  logic [9:0]   cfgLenM1 = '0;
  logic         outValid;
  logic [15:0]  outPixA, outPixB;
  logic [127:0] outTaps;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  multiLineDelay uut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineSync(lineSync),
    .pixA(pixA), .pixB(pixB), .cfgLayout(cfgLayout), .cfgSplit(cfgSplit),
    .cfgLenM1(cfgLenM1), .outValid(outValid), .outPixA(outPixA),
    .outPixB(outPixB), .outTaps(outTaps)
  );

  function automatic logic [15:0] pix(int ph, int l, int c, int s);
    logic [31:0] x;
    x = 32'(ph * 4099 + l * 257 + c * 13 + s * 7919);
    return x[15:0] ^ (x[15:0] >> 5);
  endfunction

  task automatic checkEq(string req, logic [127:0] act, logic [127:0] exp, logic [127:0] msk);
    nCmp++;
    if (((act ^ exp) & msk) != '0) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h mask=%h", req, act, exp, msk);
    end
  endtask

  // R1: reset values
  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    checkEq("R1 valid", 128'(outValid), 128'd0, '1);
    checkEq("R1 taps", outTaps, 128'd0, '1);
    checkEq("R1 pix", {96'd0, outPixA, outPixB}, 128'd0, '1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkEq("R1 after", {95'd0, outValid, outPixA, outPixB}, 128'd0, '1);
    checkEq("R1 taps after", outTaps, 128'd0, '1);
  endtask

  // Drive nLines lines of lineLen pixels under one configuration and check each sample
  task automatic runPhase(string req, int lay, bit spl, int lenCfg, int lineLen,
                          int nLines, int ph, bit gaps);
    int nL   = (lay == 1) ? 8 : 4;
    int h    = nL / 2;
    bit narrow = (lay < 2);
    int cap  = (lay == 0) ? 1024 : 512;
    int per  = (lenCfg + 1 > cap) ? cap : lenCfg + 1;
    logic [127:0] exp, msk, prev;
    for (int l = 0; l < nLines; l++) begin
      for (int c = 0; c < lineLen; c++) begin
        @(negedge clk);
        pixValid  = 1'b1;
        lineSync  = (c == 0);
        pixA      = pix(ph, l, c, 0);
        pixB      = pix(ph, l, c, 1);
        cfgLayout = 2'(lay);
        cfgSplit  = spl;
        cfgLenM1  = 10'(lenCfg);
        @(posedge clk);
        #1;
        checkEq("R2 valid", 128'(outValid), 128'd1, '1);
        checkEq("R2 pixels", {96'd0, outPixA, outPixB}, {96'd0, pixA, pixB}, '1);
        exp = '0;
        msk = '1;
        for (int j = 0; j < 8; j++) begin
          if (j < nL) begin
            int s   = (spl && j >= h) ? 1 : 0;
            int ago = (spl && j >= h) ? (j - h + 1) : (j + 1);
            int t   = l * lineLen + c - per * ago;
            if (t >= 0)
              exp[j*16 +: 16] = pix(ph, t / lineLen, t % lineLen, s) & (narrow ? 16'h00FF : 16'hFFFF);
            else
              msk[j*16 +: 16] = narrow ? 16'hFF00 : 16'h0000;
          end
        end
        checkEq(req, outTaps, exp, msk);
        prev = outTaps;
        if (gaps && (c % 7 == 3)) begin
          @(negedge clk);
          pixValid = 1'b0;
          lineSync = 1'b1;       // ignored without pixValid
          cfgLenM1 = 10'd5;      // ignored without a qualified line start
          pixA     = ~pixA;
          @(posedge clk);
          #1;
          checkEq("R5 valid", 128'(outValid), 128'd0, '1);
          checkEq("R5 taps", outTaps, prev, '1);
        end
      end
    end
    @(negedge clk);
    pixValid = 1'b0;
    lineSync = 1'b0;
  endtask

  initial begin
    testReset();
    runPhase("R3 R4 R6 R9 R12 long series", 0, 1'b0, 1023, 1024, 6, 1, 1'b0);
    runPhase("R4 R5 R7 R9 R12 short series gaps", 1, 1'b0, 299, 300, 10, 2, 1'b1);
    runPhase("R4 R8 R9 wide series", 2, 1'b0, 199, 200, 6, 3, 1'b0);
    runPhase("R10 R7 short split", 1, 1'b1, 149, 150, 6, 4, 1'b0);
    runPhase("R11 R3 short clamp", 1, 1'b0, 700, 1024, 6, 5, 1'b0);
    runPhase("R10 R8 wide split code3", 3, 1'b1, 99, 100, 5, 6, 1'b0);
    runPhase("R11 R8 wide clamp", 2, 1'b0, 1000, 512, 5, 7, 1'b0);
    runPhase("R6 R3 long short lines", 0, 1'b1, 63, 64, 5, 8, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule